// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block runs an external 8-bit successive-approximation converter that has an eight-input analog multiplexer in front of it. It generates the converter clock from the system clock. For each conversion it drives the three channel-select lines, pulses the address-latch strobe, waits out a settling window and then pulses the start strobe. It waits for the end-of-conversion line to fall and then rise again. After that it enables the converter's output for one cycle, captures the byte and presents it with its channel number on a valid/ready port. The next conversion does not begin until that result has been taken.

In scan mode the channels are visited in ascending order from 0 to `NUM_CH-1` and then wrap. In single mode the channel comes from `chan_sel`, masked to the configured channel count. When the converter clock is slow, a parameter lets the address-latch strobe and the start strobe share the same timing. A watchdog counts converter clock periods while the sequencer waits. If end-of-conversion never completes, the watchdog flags an error and returns the sequencer to idle.

The sequencer has ten states:
- `S_IDLE` goes to `S_SETUP` when `run` is high.
- `S_SETUP` goes to `S_ALE`, or to `S_START` when strobes are merged.
- `S_ALE` goes to `S_SETTLE`.
- `S_SETTLE` goes to `S_START`.
- `S_START` goes to `S_WAIT_LOW`.
- `S_WAIT_LOW` goes to `S_WAIT_HIGH` when end-of-conversion is seen low.
- `S_WAIT_HIGH` goes to `S_OE_DLY` when end-of-conversion is seen high.
- `S_OE_DLY` goes to `S_CAPTURE`.
- `S_CAPTURE` goes to `S_PRESENT`.
- `S_PRESENT` goes to `S_IDLE` when the result is accepted.
- `S_WAIT_LOW` and `S_WAIT_HIGH` also go to `S_IDLE` on a timeout.

Top module: `adc_scan_ctrl`

## Requirements
- R1: A synchronous active-high `rst` drives `ale`, `start`, `oe`, `res_valid`, `busy` and `timeout_err` low and clears the scan channel counter, so the first scan result carries channel 0.
- R2: `mux_addr[2]` is the most significant select bit and `mux_addr[0]` the least. `mux_addr` never exceeds `NUM_CH-1`, so with the default of 4 channels bit 2 stays 0.
- R3: In separate-strobe mode `ale` is high for `STROBE_LEN` system clocks. It then stays low for `SETTLE_LEN` clocks, after which `start` is high for `STROBE_LEN` clocks. `ale` has always fallen before `start` rises, and the two are never high together.
- R4: With `MERGE_STROBES=1`, `ale` and `start` are identical at every cycle and conversions still complete with correct data.
- R5: `mux_addr` is stable while `start` or `oe` is high, so the address latched by the converter equals the channel reported with the result.
- R6: Completion is recognised only after `eoc` has been seen low and then high. `oe` is high only while `eoc` is high, and each `oe` pulse is one system clock wide.
- R7: The byte on `adc_din` while `oe` is high appears on `res_data` with `res_valid`, in the cycle that `oe` falls.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data` and `res_chan` hold and no new `ale` or `start` pulse occurs.
- R9: In scan mode (`scan_mode=1`) successive results carry channels 0,1,…,`NUM_CH-1`,0,… The counter advances only when a result is accepted.
- R10: In single mode (`scan_mode=0`) the converted channel is `chan_sel & (NUM_CH-1)`.
- R11: If completion is not seen within `TIMEOUT` converter clock periods of entering the wait, `timeout_err` is set and the sequencer returns to idle without a result. The flag holds until the next conversion starts.
- R12: `adc_clk` is high for `CLK_HALF` system clocks and low for `CLK_HALF` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Begin a conversion when idle |
| scan_mode | input | 1 | 1: scan channels, 0: use `chan_sel` |
| chan_sel | input | 3 | Channel for single mode |
| eoc | input | 1 | End-of-conversion from converter |
| adc_din | input | 8 | Converter data bus |
| res_ready | input | 1 | Consumer accepts result |
| adc_clk | output | 1 | Converter clock |
| mux_addr | output | 3 | Channel-select lines, bit 2 most significant |
| ale | output | 1 | Address-latch strobe |
| start | output | 1 | Start-conversion strobe |
| oe | output | 1 | Converter output enable |
| res_valid | output | 1 | Result available |
| res_data | output | 8 | Captured conversion value |
| res_chan | output | 3 | Channel of captured value |
| busy | output | 1 | Sequencer not idle |
| timeout_err | output | 1 | Completion watchdog expired |

## Verification
The assertions assume `eoc` holds high once a conversion has completed, until the next start pulse. They also assume the converter drives `eoc` high outside a conversion, so that `oe` is high only while `eoc` is high. The bench's converter model keeps to both: it lowers `eoc` two converter clocks after the start pulse falls and raises it again only at completion, or never in hang mode. The consumer handshake is driven only at falling clock edges, with random hold times for `res_ready`. A second instance with merged strobes accepts every result at once.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_ALE,
        S_SETTLE,
        S_START,
        S_WAIT_LOW,
        S_WAIT_HIGH,
        S_OE_DLY,
        S_CAPTURE,
        S_PRESENT
    } seq_state_t;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int CLK_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    output logic adc_clk,
    output logic rise_tick
);
    localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap      = (cnt_q == CW'(CLK_HALF - 1));
    assign rise_tick = wrap && !adc_clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            adc_clk <= 1'b0;
        end else if (wrap) begin
            cnt_q   <= '0;
            adc_clk <= ~adc_clk;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_chan_ctr.sv
module adc_chan_ctr #(
    parameter int NUM_CH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    output logic [2:0] chan
);
    localparam logic [2:0] LAST = 3'(NUM_CH - 1);

    always_ff @(posedge clk) begin
        if (rst)
            chan <= '0;
        else if (advance)
            chan <= (chan == LAST) ? 3'd0 : chan + 3'd1;
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CLK_HALF      = 2,
    parameter int STROBE_LEN    = 2,
    parameter int SETTLE_LEN    = 2,
    parameter int TIMEOUT       = 100,
    parameter int NUM_CH        = 4,
    parameter bit MERGE_STROBES = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       scan_mode,
    input  logic [2:0] chan_sel,
    input  logic       eoc,
    input  logic [7:0] adc_din,
    input  logic       res_ready,
    output logic       adc_clk,
    output logic [2:0] mux_addr,
    output logic       ale,
    output logic       start,
    output logic       oe,
    output logic       res_valid,
    output logic [7:0] res_data,
    output logic [2:0] res_chan,
    output logic       busy,
    output logic       timeout_err
);
    localparam int         TMR_MAX = (STROBE_LEN > SETTLE_LEN) ? STROBE_LEN : SETTLE_LEN;
    localparam int         TW      = $clog2(TMR_MAX + 1);
    localparam int         TOW     = $clog2(TIMEOUT + 1);
    localparam logic [2:0] CH_MASK = 3'(NUM_CH - 1);

    seq_state_t     state_q, state_d;
    logic [TW-1:0]  tmr_q;
    logic [TOW-1:0] to_q;
    logic           eoc_s1, eoc_s2;
    logic           adc_tick;
    logic           waiting, expired, advance, scan_q;
    logic [2:0]     scan_chan, addr_q;

    adc_clk_div #(.CLK_HALF(CLK_HALF)) u_div (
        .clk       (clk),
        .rst       (rst),
        .adc_clk   (adc_clk),
        .rise_tick (adc_tick)
    );

    adc_chan_ctr #(.NUM_CH(NUM_CH)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .chan    (scan_chan)
    );

    assign waiting = (state_q == S_WAIT_LOW) || (state_q == S_WAIT_HIGH);
    assign expired = waiting && adc_tick && (to_q == TOW'(TIMEOUT - 1));
    assign advance = (state_q == S_PRESENT) && res_ready && scan_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (run) state_d = S_SETUP;
            S_SETUP:     state_d = MERGE_STROBES ? S_START : S_ALE;
            S_ALE:       if (tmr_q == '0) state_d = S_SETTLE;
            S_SETTLE:    if (tmr_q == '0) state_d = S_START;
            S_START:     if (tmr_q == '0) state_d = S_WAIT_LOW;
            S_WAIT_LOW:  if (expired) state_d = S_IDLE;
                         else if (!eoc_s2) state_d = S_WAIT_HIGH;
            S_WAIT_HIGH: if (expired) state_d = S_IDLE;
                         else if (eoc_s2) state_d = S_OE_DLY;
            S_OE_DLY:    state_d = S_CAPTURE;
            S_CAPTURE:   state_d = S_PRESENT;
            S_PRESENT:   if (res_ready) state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ale       = (state_q == S_ALE) || (MERGE_STROBES && (state_q == S_START));
        start     = (state_q == S_START);
        oe        = (state_q == S_CAPTURE);
        res_valid = (state_q == S_PRESENT);
        busy      = (state_q != S_IDLE);
        mux_addr  = addr_q;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q       <= '0;
            to_q        <= '0;
            eoc_s1      <= 1'b1;
            eoc_s2      <= 1'b1;
            addr_q      <= '0;
            scan_q      <= 1'b0;
            res_data    <= '0;
            res_chan    <= '0;
            timeout_err <= 1'b0;
        end else begin
            eoc_s1 <= eoc;
            eoc_s2 <= eoc_s1;

            if (state_d != state_q) begin
                if (state_d == S_SETTLE) tmr_q <= TW'(SETTLE_LEN - 1);
                else                     tmr_q <= TW'(STROBE_LEN - 1);
            end else if (tmr_q != '0) begin
                tmr_q <= tmr_q - 1'b1;
            end

            if (!waiting)      to_q <= '0;
            else if (adc_tick) to_q <= to_q + 1'b1;

            if (state_q == S_IDLE && run) begin
                addr_q      <= scan_mode ? scan_chan : (chan_sel & CH_MASK);
                scan_q      <= scan_mode;
                timeout_err <= 1'b0;
            end else if (expired) begin
                timeout_err <= 1'b1;
            end

            if (state_q == S_CAPTURE) begin
                res_data <= adc_din;
                res_chan <= addr_q;
            end
        end
    end
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
    parameter int STROBE_LEN    = 2,
    parameter int NUM_CH        = 4,
    parameter bit MERGE_STROBES = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       eoc,
    input logic       res_ready,
    input logic [2:0] mux_addr,
    input logic       ale,
    input logic       start,
    input logic       oe,
    input logic       res_valid,
    input logic [7:0] res_data,
    input logic [2:0] res_chan,
    input logic       busy,
    input logic       timeout_err
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!ale && !start && !oe && !res_valid && !busy && !timeout_err));

    assert_addr_range_R2: assert property (@(posedge clk) disable iff (rst)
        mux_addr <= 3'(NUM_CH - 1));

    if (MERGE_STROBES) begin : g_merged
        assert_strobes_equal_R4: assert property (@(posedge clk) disable iff (rst)
            ale == start);
    end else begin : g_split
        assert_strobes_apart_R3: assert property (@(posedge clk) disable iff (rst)
            !(ale && start));
    end

    if (STROBE_LEN >= 2) begin : g_width
        assert_start_width_R3: assert property (@(posedge clk) disable iff (rst)
            $rose(start) |=> start);
    end

    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (rst)
        ((start || oe) && $past(busy)) |-> $stable(mux_addr));

    assert_oe_needs_eoc_R6: assert property (@(posedge clk) disable iff (rst)
        oe |-> eoc);

    assert_oe_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        oe |=> !oe);

    assert_capture_valid_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(oe) |-> res_valid);

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan)));

    assert_no_strobe_pending_R8: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (!ale && !start));

    assert_err_idle_R11: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> !busy);
endmodule

bind adc_scan_ctrl adc_scan_chk #(
    .STROBE_LEN    (STROBE_LEN),
    .NUM_CH        (NUM_CH),
    .MERGE_STROBES (MERGE_STROBES)
) u_chk (.*);

// File: tb/sim_adc_scan_ctrl.sv
module conv_model #(
    parameter int CONV = 64
) (
    input  logic       adc_clk,
    input  logic       ale,
    input  logic       start,
    input  logic       oe,
    input  logic       hang,
    input  logic [2:0] addr,
    output logic       eoc,
    output logic [7:0] dout,
    output logic [2:0] lat,
    output int         conv_cnt,
    output int         bad_order
);
    logic       running;
    logic       ale_done;
    int         cnt;
    logic [7:0] res;

    function automatic logic [7:0] val(logic [2:0] a, int n);
        return 8'(int'(a) * 53 + n * 11 + 7);
    endfunction

    initial begin
        eoc = 1'b1; lat = '0; conv_cnt = 0; bad_order = 0;
        running = 1'b0; ale_done = 1'b0; cnt = 0; res = '0;
    end

    assign dout = oe ? res : 8'h00;

    always @(negedge ale) begin
        lat = addr;
        ale_done = 1'b1;
    end

    always @(posedge start) begin
        if (!ale_done) bad_order = bad_order + 1;
        ale_done = 1'b0;
        running  = 1'b0;
    end

    always @(negedge start) begin
        running = 1'b1;
        cnt = 0;
    end

    always @(posedge adc_clk) begin
        if (running) begin
            cnt = cnt + 1;
            if (cnt == 2) eoc = 1'b0;
            if (cnt == CONV + 2 && !hang) begin
                res = val(lat, conv_cnt);
                conv_cnt = conv_cnt + 1;
                eoc = 1'b1;
                running = 1'b0;
            end
        end
    end
endmodule

module sim_adc_scan_ctrl;
    localparam int CLK_HALF = 2;
    localparam int NUM_CH   = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, run, scan_mode, ready, hang;
    logic [2:0] chan_sel;
    logic       run1, ready1;

    logic       a_clk0, ale0, start0, oe0, valid0, busy0, err0, eoc0;
    logic [2:0] addr0, chan0, lat0;
    logic [7:0] data0, din0;
    int         cc0, bo0;

    logic       a_clk1, ale1, start1, oe1, valid1, busy1, err1, eoc1;
    logic [2:0] addr1, chan1, lat1;
    logic [7:0] data1, din1;
    int         cc1, bo1;

    int checks = 0, errors = 0;
    int starts0 = 0, oe_bad = 0, oe_wide = 0, oe_seen = 0, addr_bad = 0;
    int merge_bad = 0, u1_cnt = 0, u1_bad = 0;
    logic oe0_prev = 1'b0;

    adc_scan_ctrl u0 (
        .clk(clk), .rst(rst), .run(run), .scan_mode(scan_mode), .chan_sel(chan_sel),
        .eoc(eoc0), .adc_din(din0), .res_ready(ready), .adc_clk(a_clk0),
        .mux_addr(addr0), .ale(ale0), .start(start0), .oe(oe0), .res_valid(valid0),
        .res_data(data0), .res_chan(chan0), .busy(busy0), .timeout_err(err0)
    );

    conv_model m0 (
        .adc_clk(a_clk0), .ale(ale0), .start(start0), .oe(oe0), .hang(hang),
        .addr(addr0), .eoc(eoc0), .dout(din0), .lat(lat0), .conv_cnt(cc0), .bad_order(bo0)
    );

    adc_scan_ctrl #(.MERGE_STROBES(1'b1)) u1 (
        .clk(clk), .rst(rst), .run(run1), .scan_mode(1'b1), .chan_sel(3'd0),
        .eoc(eoc1), .adc_din(din1), .res_ready(ready1), .adc_clk(a_clk1),
        .mux_addr(addr1), .ale(ale1), .start(start1), .oe(oe1), .res_valid(valid1),
        .res_data(data1), .res_chan(chan1), .busy(busy1), .timeout_err(err1)
    );

    conv_model m1 (
        .adc_clk(a_clk1), .ale(ale1), .start(start1), .oe(oe1), .hang(1'b0),
        .addr(addr1), .eoc(eoc1), .dout(din1), .lat(lat1), .conv_cnt(cc1), .bad_order(bo1)
    );

    function automatic logic [7:0] expv(logic [2:0] a, int n);
        return 8'(int'(a) * 53 + n * 11 + 7);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge start0) starts0++;

    always @(negedge clk) begin
        if (!rst) begin
            if (oe0 && !eoc0) oe_bad++;
            if (oe0 && oe0_prev) oe_wide++;
            if (oe0) oe_seen++;
            if (addr0 > 3'(NUM_CH - 1)) addr_bad++;
            if (ale1 != start1) merge_bad++;
            if (valid1 && ready1) begin
                if (chan1 != 3'(u1_cnt % NUM_CH)) u1_bad++;
                if (data1 != expv(chan1, cc1 - 1)) u1_bad++;
                u1_cnt++;
            end
        end
        oe0_prev = oe0;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic wait_valid();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (valid0) return;
        end
    endtask

    task automatic wait_busy();
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (busy0) return;
        end
    endtask

    task automatic accept();
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
    endtask

    initial begin
        int hi, lo, t, d, s, sel;
        bit held;
        void'($urandom(32'd20240611));
        rst = 1'b1; run = 1'b0; scan_mode = 1'b0; chan_sel = '0; ready = 1'b0;
        hang = 1'b0; run1 = 1'b0; ready1 = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(!ale0 && !start0 && !oe0, "R1 strobes low", {ale0, start0, oe0}, 0);
        chk(!valid0 && !busy0 && !err0, "R1 idle flags", {valid0, busy0, err0}, 0);
        rst = 1'b0;
        run1 = 1'b1;

        // R12 converter clock shape
        while (a_clk0 !== 1'b0) @(negedge clk);
        while (a_clk0 !== 1'b1) @(negedge clk);
        hi = 0; lo = 0;
        while (a_clk0 === 1'b1) begin hi++; @(negedge clk); end
        while (a_clk0 === 1'b0) begin lo++; @(negedge clk); end
        chk(hi == CLK_HALF, "R12 high time", hi, CLK_HALF);
        chk(lo == CLK_HALF, "R12 low time", lo, CLK_HALF);

        // R9 scan with random consumer back-pressure
        scan_mode = 1'b1; run = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_valid();
            chk(valid0, "R9 result arrives", valid0, 1);
            chk(chan0 == 3'(i % NUM_CH), (i == 0) ? "R1 first channel 0" : "R9 scan order", chan0, i % NUM_CH);
            chk(data0 == expv(chan0, cc0 - 1), "R7 captured data", data0, expv(chan0, cc0 - 1));
            chk(lat0 == chan0, "R5 latched address", lat0, chan0);
            d = (i == 3) ? 40 : int'($urandom % 12);
            s = starts0; held = 1'b1;
            for (int k = 0; k < d; k++) begin
                @(negedge clk);
                if (!valid0 || starts0 != s) held = 1'b0;
            end
            chk(held, "R8 hold while not ready", held, 1);
            if (i == 7) run = 1'b0;
            accept();
        end
        while (busy0) @(negedge clk);
        chk(bo0 == 0, "R3 latch strobe before start", bo0, 0);

        // R10 single mode
        scan_mode = 1'b0;
        for (int k = 0; k < 4; k++) begin
            sel = (k == 0) ? 7 : int'($urandom % 8);
            chan_sel = 3'(sel);
            run = 1'b1;
            wait_busy();
            run = 1'b0;
            wait_valid();
            chk(chan0 == 3'(sel & (NUM_CH - 1)), "R10 single channel", chan0, sel & (NUM_CH - 1));
            chk(data0 == expv(lat0, cc0 - 1), "R7 single data", data0, expv(lat0, cc0 - 1));
            accept();
        end
        chk(addr_bad == 0, "R2 address range", addr_bad, 0);

        // R11 timeout
        hang = 1'b1; run = 1'b1;
        wait_busy();
        run = 1'b0; t = 0;
        while (!err0 && t < 1000) begin @(negedge clk); t++; end
        chk(t >= 400 && t <= 416, "R11 timeout delay", t, 408);
        chk(!busy0 && !valid0, "R11 back to idle", {busy0, valid0}, 0);
        repeat (10) @(negedge clk);
        chk(err0, "R11 flag holds", err0, 1);
        hang = 1'b0; run = 1'b1;
        wait_busy();
        run = 1'b0;
        chk(!err0, "R11 flag clears on new start", err0, 0);
        wait_valid();
        chk(valid0 && data0 == expv(chan0, cc0 - 1), "R11 recovery data", data0, expv(chan0, cc0 - 1));
        accept();

        // R6 output-enable behaviour
        chk(oe_seen > 0 && oe_bad == 0, "R6 oe only with eoc high", oe_bad, 0);
        chk(oe_wide == 0, "R6 oe one clock", oe_wide, 0);

        // R4 merged-strobe instance
        chk(merge_bad == 0, "R4 strobes identical", merge_bad, 0);
        chk(u1_cnt >= 3, "R4 merged conversions", u1_cnt, 3);
        chk(u1_bad == 0, "R4 merged results", u1_bad, 0);

        finish_run();
    end
endmodule